// File: doc/BRIEF.md
# RTC Holding Register Freeze and Write-Back Controller

This block sits between a free-running timekeeping counter chain (seconds up to a two-digit BCD century count) and the time bytes that software sees on a byte-wide register bus. When nothing is frozen, the block copies the counter value into a bank of holding bytes each time the chain signals a new second. Software can freeze that copy for a coherent multi-byte read, or open a write window in which it edits the holding bytes. When the window is closed after an edit, the edited bytes are loaded back into the counters after a fixed transfer delay.

Two control bits live in a control byte. The read-freeze bit only stops the copy from the counters. The write bit opens the edit window, and it can be set with or without the read-freeze bit. The counter chain keeps running the whole time; only the user-visible copy is held. The write-back happens only if at least one byte was actually altered. While the write-back is in flight, a busy output is high and edits are refused.

The controller has three states. IDLE means tracking, or frozen if the read-freeze bit is set. OPEN means the edit window is open. XFER means the write-back is in flight. It takes these transitions:
- IDLE to OPEN when W is written as 1.
- OPEN to IDLE when W is written as 0 and no byte was altered.
- OPEN to XFER when W is written as 0 after an alteration.
- XFER to IDLE when the transfer timer expires.

Top module: `rtc_hold_xfer`

## Requirements
- R1: After reset, the read-freeze bit and the write bit are 0, `xfer_busy` and `cnt_load` are 0, and every holding byte reads 0.
- R2: The control byte is at address NUM_REGS (7 by default). Bit 0 is the read-freeze bit R and bit 1 is the write bit W. Reads return W in bit 1, R in bit 0 and 0 in the other bits. Addresses 0 to NUM_REGS-1 read holding byte i, which is bits [8i+7:8i] of the counter buses. Any other address reads 0.
- R3: In IDLE with R=0, a cycle with `sec_tick` high copies `cnt_val` into the holding bytes, and the new value is readable from the next cycle.
- R4: While R=1, ticks do not change the holding bytes. After R is cleared, the next tick copies the counters again.
- R5: R and W are independent. W can be set with R at 0, and R keeps the value written alongside W.
- R6: While W=1 (state OPEN), ticks are ignored and bus writes to time addresses update the holding bytes, which read back the written value.
- R7: Bus writes to time addresses in IDLE or XFER leave the holding bytes unchanged.
- R8: Writing W=0 when no byte was altered returns the controller to IDLE in one cycle, with no busy cycle and no load strobe.
- R9: Writing W=0 after an alteration raises `xfer_busy` from the next cycle for exactly XFER_CYC cycles. `cnt_load` is high for one cycle, the last busy cycle, and `cnt_load_val` then equals the holding bytes.
- R10: During XFER, control writes update R, but a W=1 request is ignored and W reads 0.
- R11: A write of a value equal to the byte's current content does not count as an alteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sec_tick | input | 1 | High in a cycle where the counter chain presents a new value |
| cnt_val | input | NUM_REGS*8 | Current counter chain value, byte i in bits [8i+7:8i] |
| cnt_load | output | 1 | One-cycle strobe: counters take `cnt_load_val` |
| cnt_load_val | output | NUM_REGS*8 | Value to load into the counters |
| xfer_busy | output | 1 | High while the write-back is in flight |

## Verification
The bench first runs plain tracking with both bits clear. It then holds R across several ticks, which tells a working read freeze apart from a copy that keeps running. It opens the window, writes back an unchanged byte and closes the window; this separates a change-sensitive write-back from one that fires on any closing of the window. A full edit-and-close sequence, with a time write and a W request issued during the transfer, checks the busy length, the load strobe and value, and that busy refuses edits. A behavioural model tracks every cycle to catch divergence between these directed points.

// File: rtl/rtc_hold_pkg.sv
package rtc_hold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_XFER = 2'd2
    } xfer_state_e;

    localparam int CTRL_R_BIT = 0;
    localparam int CTRL_W_BIT = 1;
endpackage

// File: rtl/rtc_xfer_fsm.sv
module rtc_xfer_fsm
    import rtc_hold_pkg::*;
#(
    parameter int XFER_CYC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [7:0]  ctrl_wdata,
    input  logic        dirty,
    output xfer_state_e state,
    output logic        rd_freeze,
    output logic        xfer_busy,
    output logic        load_stb
);
    localparam int TMR_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(XFER_CYC - 1);

    xfer_state_e      st_q, st_d;
    logic [TMR_W-1:0] tmr_q;
    logic             r_q;
    logic             tmr_last;

    assign tmr_last = (tmr_q == TMR_LAST);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (ctrl_wr && ctrl_wdata[CTRL_W_BIT]) st_d = ST_OPEN;
            ST_OPEN: if (ctrl_wr && !ctrl_wdata[CTRL_W_BIT])
                         st_d = dirty ? ST_XFER : ST_IDLE;
            ST_XFER: if (tmr_last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register, transfer timer, read-freeze bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
            r_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q != ST_XFER) tmr_q <= '0;
            else                 tmr_q <= tmr_q + 1'b1;
            if (ctrl_wr) r_q <= ctrl_wdata[CTRL_R_BIT];
        end
    end

    // outputs
    always_comb begin
        state     = st_q;
        rd_freeze = r_q;
        xfer_busy = (st_q == ST_XFER);
        load_stb  = (st_q == ST_XFER) && tmr_last;
    end

    // R9
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);
    // R9
    xfer_from_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> ($past(st_q) == ST_OPEN));
    // R10
    no_open_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER && ctrl_wr) |=> (st_q != ST_OPEN));
    // R8
    clean_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && ctrl_wr && !ctrl_wdata[CTRL_W_BIT] && !dirty)
        |=> (st_q == ST_IDLE));
endmodule

// File: rtl/rtc_hold_bank.sv
module rtc_hold_bank
    import rtc_hold_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int ADDR_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  xfer_state_e           state,
    input  logic                  rd_freeze,
    input  logic                  sec_tick,
    input  logic [NUM_REGS*8-1:0] cnt_val,
    input  logic                  wr_time,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    output logic [NUM_REGS*8-1:0] hold_flat,
    output logic [7:0]            sel_byte,
    output logic                  dirty
);
    logic [7:0] hold_q [NUM_REGS];
    logic       dirty_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[i] <= '0;
            end else if (state == ST_OPEN) begin
                if (wr_time && addr == ADDR_W'(i)) hold_q[i] <= wdata;
            end else if (state == ST_IDLE && !rd_freeze && sec_tick) begin
                hold_q[i] <= cnt_val[8*i +: 8];
            end
        end
        assign hold_flat[8*i +: 8] = hold_q[i];
    end

    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr == ADDR_W'(i)) sel_byte = hold_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_OPEN) dirty_q <= 1'b0;
        else if (wr_time && wdata != sel_byte) dirty_q <= 1'b1;
    end
    assign dirty = dirty_q;

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER || (state == ST_IDLE && rd_freeze)) |=> $stable(hold_flat));
    // R7
    no_tick_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OPEN && !sec_tick) |=> $stable(hold_flat));
    // R11
    dirty_only_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OPEN) |=> !dirty_q);
endmodule

// File: rtl/rtc_hold_xfer.sv
module rtc_hold_xfer
    import rtc_hold_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int ADDR_W   = 3,
    parameter int XFER_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic                  sec_tick,
    input  logic [NUM_REGS*8-1:0] cnt_val,
    output logic                  cnt_load,
    output logic [NUM_REGS*8-1:0] cnt_load_val,
    output logic                  xfer_busy
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

    xfer_state_e state;
    logic        rd_freeze, dirty, ctrl_wr, time_wr;
    logic [7:0]  sel_byte;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
    assign time_wr = bus_wr && (bus_addr < CTRL_ADDR);

    rtc_xfer_fsm #(.XFER_CYC(XFER_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_wdata(bus_wdata),
        .dirty     (dirty),
        .state     (state),
        .rd_freeze (rd_freeze),
        .xfer_busy (xfer_busy),
        .load_stb  (cnt_load)
    );

    rtc_hold_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .rd_freeze(rd_freeze),
        .sec_tick (sec_tick),
        .cnt_val  (cnt_val),
        .wr_time  (time_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .hold_flat(cnt_load_val),
        .sel_byte (sel_byte),
        .dirty    (dirty)
    );

    always_comb begin
        if (bus_addr < CTRL_ADDR)       bus_rdata = sel_byte;
        else if (bus_addr == CTRL_ADDR) bus_rdata = {6'b0, state == ST_OPEN, rd_freeze};
        else                            bus_rdata = '0;
    end

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CTRL_ADDR) |-> (bus_rdata[7:2] == 6'b0));
endmodule

// File: tb/tb_rtc_hold_xfer.sv
module tb_rtc_hold_xfer;
    localparam int NR = 7;
    localparam int AW = 3;
    localparam int XC = 8;
    localparam int CTRL = NR;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, sec_tick = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [NR*8-1:0] cnt_val = '0, cnt_load_val;
    logic cnt_load, xfer_busy;

    rtc_hold_xfer #(.NUM_REGS(NR), .ADDR_W(AW), .XFER_CYC(XC)) dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    string phase = "R1";

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // counter chain environment
    logic [NR*8-1:0] env = '0, last_ld = '0;
    int div = 0;
    always @(negedge clk) begin
        if (cnt_load) begin env = cnt_load_val; last_ld = cnt_load_val; end
        if (!rst_n) begin div = 0; sec_tick = 0; end
        else if (div == 3) begin div = 0; env = env + 1; sec_tick = 1; end
        else begin div++; sec_tick = 0; end
        cnt_val = env;
    end

    // behavioural reference model
    logic [7:0] m_hold [NR];
    logic m_r = 0, m_dirty = 0;
    int m_st = 0, m_tmr = 0, run = 0, loads = 0;
    always @(posedge clk) begin
        logic cw, tw;
        logic [7:0] e_rd;
        logic [NR*8-1:0] e_ldv;
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) m_hold[i] = 0;
            m_r = 0; m_st = 0; m_tmr = 0; m_dirty = 0;
        end else begin
            cw = bus_wr && bus_addr == CTRL;
            tw = bus_wr && bus_addr < NR;
            case (m_st)
                0: begin
                    if (sec_tick && !m_r)
                        for (int i = 0; i < NR; i++) m_hold[i] = cnt_val[8*i +: 8];
                    if (cw) begin
                        m_r = bus_wdata[0];
                        if (bus_wdata[1]) begin m_st = 1; m_dirty = 0; end
                    end
                end
                1: begin
                    if (tw && bus_wdata != m_hold[bus_addr]) begin
                        m_hold[bus_addr] = bus_wdata; m_dirty = 1;
                    end
                    if (cw) begin
                        m_r = bus_wdata[0];
                        if (!bus_wdata[1]) begin m_st = m_dirty ? 2 : 0; m_tmr = 0; end
                    end
                end
                default: begin
                    if (cw) m_r = bus_wdata[0];
                    if (m_tmr == XC - 1) m_st = 0; else m_tmr++;
                end
            endcase
        end
        #5;
        if (bus_addr < NR) e_rd = m_hold[bus_addr];
        else if (bus_addr == CTRL) e_rd = {6'b0, m_st == 1, m_r};
        else e_rd = 0;
        for (int i = 0; i < NR; i++) e_ldv[8*i +: 8] = m_hold[i];
        chk({phase, " rdata"}, bus_rdata, e_rd);
        chk("R9 busy", xfer_busy, m_st == 2);
        chk("R9 load strobe", cnt_load, (m_st == 2) && (m_tmr == XC - 1));
        chk("R9 load value", cnt_load_val, e_ldv);
        if (xfer_busy) begin
            run++;
            if (cnt_load) loads++;
        end else if (run != 0) begin
            chk("R9 busy length", run, XC);
            chk("R9 one load per transfer", loads, 1);
            run = 0; loads = 0;
        end
    end

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(int a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = AW'(a);
        #2 v = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R9: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v, v0;
        logic [NR*8-1:0] exp_ld;
        repeat (3) @(negedge clk);
        rst_n = 1;
        phase = "R1";
        rd(CTRL, v); chk("R1 control after reset", v, 0);
        chk("R1 busy after reset", xfer_busy, 0);
        rd(0, v); chk("R1 hold after reset", v, 0);

        phase = "R3";
        repeat (20) @(negedge clk);
        rd(0, v); chk("R3 holding tracks counters", v != 0, 1);

        phase = "R4";
        wr(CTRL, 8'h01);
        rd(0, v0);
        repeat (12) @(negedge clk);
        rd(0, v); chk("R4 frozen across ticks", v, v0);
        wr(CTRL, 8'h00);
        repeat (6) @(negedge clk);
        rd(0, v); chk("R4 resumes after clear", v != v0, 1);

        phase = "R5";
        wr(CTRL, 8'h02); rd(CTRL, v); chk("R5 W without R", v, 8'h02);
        wr(CTRL, 8'h03); rd(CTRL, v); chk("R5 R with W", v, 8'h03);
        wr(CTRL, 8'h01); rd(CTRL, v); chk("R5 R kept as W clears", v, 8'h01);
        chk("R8 no busy after clean close", xfer_busy, 0);

        phase = "R11";
        wr(CTRL, 8'h02);
        rd(3, v);
        wr(3, v);
        phase = "R8";
        wr(CTRL, 8'h00);
        chk("R8 same-value write gives no busy", xfer_busy, 0);
        repeat (3) @(negedge clk);
        chk("R11 still no busy", xfer_busy, 0);
        rd(CTRL, v); chk("R8 back to idle", v, 0);

        phase = "R6";
        wr(CTRL, 8'h02);
        for (int i = 0; i < NR; i++) wr(i, 8'h10 + 8'(i));
        repeat (10) @(negedge clk);
        for (int i = 0; i < NR; i++) begin
            rd(i, v); chk("R6 write readback across ticks", v, 8'h10 + 8'(i));
        end

        phase = "R9";
        wr(CTRL, 8'h00);
        chk("R9 busy after altered close", xfer_busy, 1);
        phase = "R7";
        wr(1, 8'h99);
        phase = "R10";
        wr(CTRL, 8'h02);
        rd(CTRL, v); chk("R10 W refused during busy", v[1], 0);
        rd(1, v); chk("R7 write during busy ignored", v, 8'h11);
        repeat (12) @(negedge clk);
        for (int i = 0; i < NR; i++) exp_ld[8*i +: 8] = 8'h10 + 8'(i);
        chk("R9 loaded counter value", last_ld, exp_ld);

        phase = "R7";
        wr(CTRL, 8'h01);
        rd(0, v0);
        wr(0, ~v0);
        rd(0, v); chk("R7 write in idle ignored", v, v0);
        wr(CTRL, 8'h00);
        repeat (8) @(negedge clk);
        finish_run();
    end
endmodule